// File: doc/BRIEF.md
# Noise-Filtered Input Capture Unit

This block timestamps transitions on one external input against a 16-bit free-running counter. The pin is first brought into the system clock domain by a two-stage synchronizer. It then passes through an optional majority-vote noise filter. That filter holds the last four samples, taken only on cycles where a sampling strobe is high, and its output switches with hysteresis. A programmable edge detector watches the resulting level. On every selected transition it copies the counter into a capture register and raises a one-cycle interrupt request.

The filter can be switched in or out at run time. While it is switched out, its history and output sit cleared at LOW, so each time it is switched in it starts from a known state. On the cycle the level source changes, the edge detector takes the new level as its reference and does not report a transition.

The filter and the edge detector are each a two-state machine. The filter has states FLT_LOW and FLT_HIGH. The transition FLT_LOW to FLT_HIGH fires on a strobe after which at least three of the four held samples are HIGH. The transition FLT_HIGH to FLT_LOW fires on a strobe after which at least three are LOW. A disable or a reset forces FLT_LOW. The edge detector has states EDG_LOW and EDG_HIGH and follows the selected level every cycle. EDG_LOW to EDG_HIGH is a rising edge, and EDG_HIGH to EDG_LOW is a falling edge. Each of these is reported only if the edge select allows it.

Top module: `noise_capture_unit`

## Requirements
- R1: While `cnt_run` is 1 the counter increases by one on every clock; while it is 0 the counter holds its value.
- R2: The counter wraps from 16'hFFFF to 16'h0000.
- R3: With the filter off, a pin change that the edge select allows loads `cap_val` with the counter value of the capture clock edge. That edge is the third rising clock edge after the pin changes. `cap_irq` is high for the cycle after that edge.
- R4: `edge_sel` encoding: 2'b00 reports nothing, 2'b01 reports rising edges only, 2'b10 reports falling edges only, 2'b11 reports both.
- R5: With the filter on, samples are taken only on strobe cycles. The filtered level goes HIGH on the strobe after which at least 3 of the last 4 samples are HIGH. A capture follows on the next clock edge.
- R6: The filtered level returns LOW only on a strobe after which at least 3 of the 4 samples are LOW. With a 2/2 split it keeps the HIGH level.
- R7: A pin pulse that is seen by only one strobe never changes the filtered level, so it produces no capture.
- R8: Reset is synchronous and active high. It clears the counter, `cap_val`, `cap_irq` and the filter state to zero or LOW.
- R9: Changing `flt_en` never causes a capture. Whenever the filter is enabled, it starts from an all-LOW history.
- R10: `cap_val` changes only on a capture, and each capture gives `cap_irq` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw asynchronous input pin |
| samp_stb | input | 1 | One-cycle sampling strobe for the filter |
| flt_en | input | 1 | 1 = filtered level feeds the edge detector, 0 = synchronized raw level |
| edge_sel | input | 2 | Valid edge select (see R4) |
| cnt_run | input | 1 | Counter run enable |
| cap_val | output | 16 | Capture register |
| cnt_val | output | 16 | Free-running counter value |
| cap_irq | output | 1 | One-cycle capture interrupt request |

## Verification
On the bypass path the pin passes two synchronizer stages and then the capture register. So the bench changes the pin on a falling clock edge and reads `cnt_val` after the second rising edge, since that is the value the third edge stores. It then checks `cap_irq` and `cap_val` after the third edge, and checks that `cap_irq` is low one cycle later. With the filter on, the level changes on the strobe edge itself and the capture lands one edge later. The bench therefore reads the expected counter value right after the strobe cycle and checks the capture one cycle after that. Where a case must not capture, the bench counts interrupt pulses over a window that reaches past the latest cycle a capture could appear. It also confirms that `cap_val` is unchanged.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_e;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edg_state_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter
    import cap_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ON_TH  = 3,
    parameter int OFF_TH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic strobe,
    input  logic din,
    output logic level
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] hist_q, hist_nxt;
    logic [CW-1:0]    ones;
    flt_state_e       st_q, st_nxt;

    always_comb begin
        hist_nxt = {hist_q[DEPTH-2:0], din};
        ones     = CW'($countones(hist_nxt));
        st_nxt   = st_q;
        unique case (st_q)
            FLT_LOW:  if (ones >= CW'(ON_TH))           st_nxt = FLT_HIGH;
            FLT_HIGH: if ((CW'(DEPTH) - ones) >= CW'(OFF_TH)) st_nxt = FLT_LOW;
            default:  st_nxt = FLT_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            hist_q <= '0;
            st_q   <= FLT_LOW;
        end else if (strobe) begin
            hist_q <= hist_nxt;
            st_q   <= st_nxt;
        end
    end

    always_comb begin
        level = (st_q == FLT_HIGH);
    end
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (run) count <= count + W'(1);
    end
endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lvl_raw,
    input  logic         lvl_flt,
    input  logic         use_flt,
    input  logic [1:0]   sel,
    input  logic [W-1:0] count,
    output logic [W-1:0] cap_val,
    output logic         cap_irq
);
    edg_state_e st_q, st_nxt;
    logic       use_q;
    logic       lvl;
    logic       src_chg;
    logic       hit;
    edge_sel_e  mode;

    always_comb begin
        mode    = edge_sel_e'(sel);
        lvl     = use_flt ? lvl_flt : lvl_raw;
        src_chg = (use_flt != use_q);
        st_nxt  = lvl ? EDG_HIGH : EDG_LOW;
        hit     = 1'b0;
        unique case (st_q)
            EDG_LOW:  hit = lvl  && (mode == EDGE_RISE || mode == EDGE_BOTH);
            EDG_HIGH: hit = !lvl && (mode == EDGE_FALL || mode == EDGE_BOTH);
            default:  hit = 1'b0;
        endcase
        if (src_chg) hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= EDG_LOW;
            use_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            use_q <= use_flt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
            cap_irq <= 1'b0;
        end else begin
            cap_irq <= hit;
            if (hit) cap_val <= count;
        end
    end
endmodule

// File: rtl/noise_capture_unit.sv
module noise_capture_unit #(
    parameter int CNT_W     = 16,
    parameter int SYNC_LEN  = 2,
    parameter int FLT_DEPTH = 4,
    parameter int FLT_VOTE  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  logic             samp_stb,
    input  logic             flt_en,
    input  logic [1:0]       edge_sel,
    input  logic             cnt_run,
    output logic [CNT_W-1:0] cap_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cap_irq
);
    logic pin_sync;
    logic filt_lvl;

    cap_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pin_in),
        .d_out (pin_sync)
    );

    cap_filter #(
        .DEPTH  (FLT_DEPTH),
        .ON_TH  (FLT_VOTE),
        .OFF_TH (FLT_VOTE)
    ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .enable (flt_en),
        .strobe (samp_stb),
        .din    (pin_sync),
        .level  (filt_lvl)
    );

    cap_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (cnt_run),
        .count (cnt_val)
    );

    cap_edge #(.W(CNT_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl_raw (pin_sync),
        .lvl_flt (filt_lvl),
        .use_flt (flt_en),
        .sel     (edge_sel),
        .count   (cnt_val),
        .cap_val (cap_val),
        .cap_irq (cap_irq)
    );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         samp_stb,
    input logic         flt_en,
    input logic [1:0]   edge_sel,
    input logic         cnt_run,
    input logic [W-1:0] cap_val,
    input logic [W-1:0] cnt_val,
    input logic         cap_irq,
    input logic         filt_lvl
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        cnt_run |=> (cnt_val == $past(cnt_val) + W'(1)));                 // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cnt_run |=> $stable(cnt_val));                                   // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_run && (cnt_val == {W{1'b1}})) |=> (cnt_val == '0));         // R2
    AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        cap_irq |-> (cap_val == $past(cnt_val)));                         // R3
    AST_SEL_NONE: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == 2'b00) |=> !cap_irq);                                // R4
    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flt_en && !samp_stb) |=> $stable(filt_lvl));                    // R5
    AST_FLT_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !flt_en |=> !filt_lvl);                                           // R9
    AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (flt_en != $past(flt_en)) |=> !cap_irq);                          // R9
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_irq |-> $stable(cap_val));                                   // R10
endmodule

bind noise_capture_unit cap_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .samp_stb (samp_stb),
    .flt_en   (flt_en),
    .edge_sel (edge_sel),
    .cnt_run  (cnt_run),
    .cap_val  (cap_val),
    .cnt_val  (cnt_val),
    .cap_irq  (cap_irq),
    .filt_lvl (filt_lvl)
);

// File: tb/sim_noise_capture_unit.sv
`timescale 1ns/1ps
module sim_noise_capture_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_in = 1'b0;
    logic        samp_stb = 1'b0;
    logic        flt_en = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        cnt_run = 1'b0;
    logic [15:0] cap_val, cnt_val;
    logic        cap_irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    noise_capture_unit u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .samp_stb(samp_stb),
        .flt_en(flt_en), .edge_sel(edge_sel), .cnt_run(cnt_run),
        .cap_val(cap_val), .cnt_val(cnt_val), .cap_irq(cap_irq)
    );

    always @(negedge clk) if (cap_irq) irq_seen++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_stb();
        @(negedge clk) samp_stb = 1'b1;
        @(negedge clk) samp_stb = 1'b0;
    endtask

    // Bypass path: pin change, capture on third rising edge.
    task automatic bypass_edge(input logic v, input bit want, input string tag);
        int base;
        logic [15:0] old_cap, exp;
        base = irq_seen;
        old_cap = cap_val;
        @(negedge clk) pin_in = v;
        @(negedge clk);
        @(negedge clk) exp = cnt_val;
        @(negedge clk);
        chk(cap_irq == want, {tag, " irq"}, cap_irq, want);
        if (want) chk(cap_val == exp, {tag, " cap"}, cap_val, exp);
        else      chk(cap_val == old_cap, {tag, " cap held"}, cap_val, old_cap);
        @(negedge clk);
        chk(cap_irq == 1'b0, {tag, " R10 pulse width"}, cap_irq, 0);
        wait_cyc(2);
        chk(irq_seen - base == int'(want), {tag, " R10 pulse count"}, irq_seen - base, want);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk(cnt_val == 16'h0 && cap_val == 16'h0 && cap_irq == 1'b0, "R8 reset state",
            {cnt_val, cap_val}, 0);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_count();
        logic [15:0] a;
        @(negedge clk) cnt_run = 1'b1;
        @(negedge clk) a = cnt_val;
        @(negedge clk);
        chk(cnt_val == a + 16'd1, "R1 count step", cnt_val, a + 16'd1);
        cnt_run = 1'b0;
        a = cnt_val;
        wait_cyc(5);
        chk(cnt_val == a, "R1 count hold", cnt_val, a);
        cnt_run = 1'b1;
    endtask

    task automatic t_wrap();
        while (cnt_val != 16'hFFFF) @(negedge clk);
        @(negedge clk);
        chk(cnt_val == 16'h0000, "R2 wrap", cnt_val, 0);
    endtask

    task automatic t_edges();
        flt_en = 1'b0;
        edge_sel = 2'b00;
        bypass_edge(1'b1, 1'b0, "R4 none rise");
        bypass_edge(1'b0, 1'b0, "R4 none fall");
        edge_sel = 2'b01;
        bypass_edge(1'b1, 1'b1, "R3 rise capture");
        bypass_edge(1'b0, 1'b0, "R4 rise-only ignores fall");
        edge_sel = 2'b10;
        bypass_edge(1'b1, 1'b0, "R4 fall-only ignores rise");
        bypass_edge(1'b0, 1'b1, "R4 fall-only captures fall");
        edge_sel = 2'b11;
        bypass_edge(1'b1, 1'b1, "R4 both rise");
        bypass_edge(1'b0, 1'b1, "R4 both fall");
    endtask

    task automatic t_filter();
        int base;
        logic [15:0] exp;
        edge_sel = 2'b11;
        base = irq_seen;
        @(negedge clk) flt_en = 1'b1;
        wait_cyc(4);
        chk(irq_seen == base, "R9 enable quiet", irq_seen - base, 0);
        // rise: need three HIGH samples
        pin_in = 1'b1;
        wait_cyc(6);
        chk(irq_seen == base, "R5 no strobe no sample", irq_seen - base, 0);
        pulse_stb();
        pulse_stb();
        wait_cyc(2);
        chk(irq_seen == base, "R5 two samples not enough", irq_seen - base, 0);
        pulse_stb();
        exp = cnt_val;
        @(negedge clk);
        chk(cap_irq == 1'b1 && cap_val == exp, "R5 filtered rise capture", cap_val, exp);
        pulse_stb();
        // hysteresis: 1110, 1100 hold HIGH; 1000 goes LOW
        pin_in = 1'b0;
        wait_cyc(3);
        base = irq_seen;
        pulse_stb();
        pulse_stb();
        wait_cyc(2);
        chk(irq_seen == base, "R6 2/2 split holds HIGH", irq_seen - base, 0);
        pulse_stb();
        exp = cnt_val;
        @(negedge clk);
        chk(cap_irq == 1'b1 && cap_val == exp, "R6 filtered fall capture", cap_val, exp);
        pulse_stb();
        // short pulse seen by one strobe
        base = irq_seen;
        pin_in = 1'b1;
        wait_cyc(3);
        pulse_stb();
        pin_in = 1'b0;
        wait_cyc(3);
        pulse_stb();
        pulse_stb();
        pulse_stb();
        wait_cyc(2);
        chk(irq_seen == base, "R7 short pulse rejected", irq_seen - base, 0);
    endtask

    task automatic t_switch();
        int base;
        logic [15:0] old_cap, exp;
        edge_sel = 2'b11;
        base = irq_seen;
        old_cap = cap_val;
        pin_in = 1'b1;
        wait_cyc(4);
        @(negedge clk) flt_en = 1'b0;
        wait_cyc(4);
        chk(irq_seen == base && cap_val == old_cap, "R9 disable quiet", irq_seen - base, 0);
        @(negedge clk) flt_en = 1'b1;
        wait_cyc(4);
        chk(irq_seen == base && cap_val == old_cap, "R9 re-enable quiet", irq_seen - base, 0);
        pulse_stb();
        pulse_stb();
        wait_cyc(2);
        chk(irq_seen == base, "R9 history cleared", irq_seen - base, 0);
        pulse_stb();
        exp = cnt_val;
        @(negedge clk);
        chk(cap_irq == 1'b1 && cap_val == exp, "R9 fresh filter rise", cap_val, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_count();
        t_edges();
        t_filter();
        t_switch();
        t_wrap();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule